// File: doc/BRIEF.md
# Decimal-Rollover Seconds/Nanoseconds Time Counter

This block keeps wall-clock time in two 32-bit words. The low word holds nanoseconds within the current second. The high word holds elapsed whole seconds. An external reference clock is brought into the core clock domain as a single-cycle enable. On each enable the nanosecond word grows by a fixed step. The step matches the reference period and is picked by a 2-bit select. The nanosecond word never passes one billion. When the step brings it to that value it returns to zero, and the seconds word counts up by one. The pair is therefore not a plain 64-bit binary count.

Software, or a neighbouring block, can load either word at any time through its own write strobe and data bus. A load takes priority over that cycle's enable. Both words are always visible on output buses, so reading them needs no handshake.

Top module: `ns_rtc`

## Requirements
- R1: After reset both words read 0.
- R2: On an enable with no write, when the nanosecond word plus the step is below the rollover value (default 1,000,000,000), the nanosecond word grows by the step and the seconds word holds.
- R3: On an enable with no write, when the nanosecond word plus the step is at or above the rollover value, the nanosecond word becomes 0 and the seconds word grows by one.
- R4: The step select encoding is as follows: 2'b00 gives 128 ns, 2'b01 gives 64 ns, 2'b10 gives 32 ns, and 2'b11 gives 32 ns. Each select is read in the cycle of the enable.
- R5: With no enable and no write, both words hold.
- R6: A nanosecond write loads its data on the next edge.
- R7: A seconds write loads its data on the next edge.
- R8: Any write in a cycle cancels that cycle's enable. The word that is not written holds.
- R9: The seconds word is a binary counter that rolls from 0xFFFFFFFF to 0 on a carry.
- R10: A nanosecond value loaded at or above the rollover value is held as written. The next enable sets it to 0 and carries one second.
- R11: With the 128 ns step, counting from 0 leaves bits 6:0 of the nanosecond word at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle enable from the reference clock |
| step_sel_i | input | 2 | Step select (R4) |
| ns_we_i | input | 1 | Nanosecond word write strobe |
| ns_wdata_i | input | 32 | Nanosecond write data |
| sec_we_i | input | 1 | Seconds word write strobe |
| sec_wdata_i | input | 32 | Seconds write data |
| ns_o | output | 32 | Nanosecond word |
| sec_o | output | 32 | Seconds word |

## Verification
The bench builds the block with its default parameters: 32-bit words, a rollover of one billion and a largest step of 128. Reaching a rollover by counting alone would take millions of enables. The bench instead loads the nanosecond word one or two steps below the rollover, or above it. It also loads the seconds word with all ones. These loads put both carries and the seconds wrap within a single enable. A separate run of twenty enables from zero covers the low-bit pattern of the 128 ns step.

// File: rtl/ns_rtc_pkg.sv
package ns_rtc_pkg;
  typedef enum logic [1:0] {
    STEP_X1 = 2'b00,
    STEP_X2 = 2'b01,
    STEP_X4 = 2'b10,
    STEP_RSV = 2'b11
  } step_sel_e;

  localparam int unsigned NUM_SEL = 4;
endpackage

// File: rtl/ns_rtc_step.sv
module ns_rtc_step #(
  parameter int unsigned WIDTH    = 32,
  parameter int unsigned STEP_MAX = 128
) (
  input  logic [1:0]       sel_i,
  output logic [WIDTH-1:0] step_o
);
  import ns_rtc_pkg::*;

  logic [WIDTH-1:0] step_tbl [NUM_SEL];

  // Each select halves the step; the reserved code clamps to the finest one.
  for (genvar g = 0; g < NUM_SEL; g++) begin : g_tbl
    localparam int unsigned SHIFT = (g > 2) ? 2 : g;
    assign step_tbl[g] = WIDTH'(STEP_MAX >> SHIFT);
  end

  assign step_o = step_tbl[sel_i];
endmodule

// File: rtl/ns_rtc_lo.sv
module ns_rtc_lo #(
  parameter int unsigned WIDTH   = 32,
  parameter int unsigned WRAP_NS = 1000000000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic [WIDTH-1:0] step_i,
  input  logic             we_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic             carry_o
);
  localparam logic [WIDTH:0] WRAP_V = (WIDTH+1)'(WRAP_NS);

  logic [WIDTH-1:0] cnt_q, cnt_d;
  logic [WIDTH:0]   sum;
  logic             at_wrap;

  assign sum     = {1'b0, cnt_q} + {1'b0, step_i};
  assign at_wrap = (sum >= WRAP_V);
  assign carry_o = adv_i & at_wrap;

  always_comb begin
    cnt_d = cnt_q;
    if (we_i)          cnt_d = wdata_i;
    else if (adv_i)    cnt_d = at_wrap ? '0 : sum[WIDTH-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ns_rtc_hi.sv
module ns_rtc_hi #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             we_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] cnt_o
);
  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (we_i)  cnt_q <= wdata_i;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ns_rtc.sv
module ns_rtc #(
  parameter int unsigned WIDTH    = 32,
  parameter int unsigned WRAP_NS  = 1000000000,
  parameter int unsigned STEP_MAX = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [1:0]       step_sel_i,
  input  logic             ns_we_i,
  input  logic [WIDTH-1:0] ns_wdata_i,
  input  logic             sec_we_i,
  input  logic [WIDTH-1:0] sec_wdata_i,
  output logic [WIDTH-1:0] ns_o,
  output logic [WIDTH-1:0] sec_o
);
  logic [WIDTH-1:0] step;
  logic             adv;
  logic             carry;

  // Any write owns the cycle; the enable is dropped, not deferred.
  assign adv = tick_i & ~ns_we_i & ~sec_we_i;

  ns_rtc_step #(.WIDTH(WIDTH), .STEP_MAX(STEP_MAX)) u_step (
    .sel_i  (step_sel_i),
    .step_o (step)
  );

  ns_rtc_lo #(.WIDTH(WIDTH), .WRAP_NS(WRAP_NS)) u_lo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .adv_i   (adv),
    .step_i  (step),
    .we_i    (ns_we_i),
    .wdata_i (ns_wdata_i),
    .cnt_o   (ns_o),
    .carry_o (carry)
  );

  ns_rtc_hi #(.WIDTH(WIDTH)) u_hi (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (carry),
    .we_i    (sec_we_i),
    .wdata_i (sec_wdata_i),
    .cnt_o   (sec_o)
  );
endmodule

// File: rtl/ns_rtc_chk.sv
module ns_rtc_chk #(
  parameter int unsigned WIDTH    = 32,
  parameter int unsigned WRAP_NS  = 1000000000,
  parameter int unsigned STEP_MAX = 128
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic [1:0]       step_sel_i,
  input logic             ns_we_i,
  input logic [WIDTH-1:0] ns_wdata_i,
  input logic             sec_we_i,
  input logic [WIDTH-1:0] sec_wdata_i,
  input logic [WIDTH-1:0] ns_o,
  input logic [WIDTH-1:0] sec_o
);
  localparam logic [WIDTH:0] WRAP_V = (WIDTH+1)'(WRAP_NS);

  logic [WIDTH-1:0] step_c;
  logic [WIDTH:0]   sum_c;
  logic             idle_c, adv_c;

  always_comb begin
    case (step_sel_i)
      2'b00:   step_c = WIDTH'(STEP_MAX);
      2'b01:   step_c = WIDTH'(STEP_MAX / 2);
      default: step_c = WIDTH'(STEP_MAX / 4);
    endcase
  end

  assign sum_c  = {1'b0, ns_o} + {1'b0, step_c};
  assign adv_c  = tick_i && !ns_we_i && !sec_we_i;
  assign idle_c = !tick_i && !ns_we_i && !sec_we_i;

  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_c && sum_c < WRAP_V) |=> (ns_o == $past(sum_c[WIDTH-1:0])) && $stable(sec_o));

  assert_rollover_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_c && sum_c >= WRAP_V) |=> (ns_o == '0) && (sec_o == WIDTH'($past(sec_o) + 1'b1)));

  assert_idle_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_c |=> $stable(ns_o) && $stable(sec_o));

  assert_ns_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ns_we_i |=> ns_o == $past(ns_wdata_i));

  assert_sec_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_we_i |=> sec_o == $past(sec_wdata_i));

  assert_ns_write_blocks_sec_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ns_we_i && !sec_we_i) |=> $stable(sec_o));

  assert_sec_write_blocks_ns_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_we_i && !ns_we_i) |=> $stable(ns_o));
endmodule

bind ns_rtc ns_rtc_chk #(.WIDTH(WIDTH), .WRAP_NS(WRAP_NS), .STEP_MAX(STEP_MAX)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .step_sel_i  (step_sel_i),
  .ns_we_i     (ns_we_i),
  .ns_wdata_i  (ns_wdata_i),
  .sec_we_i    (sec_we_i),
  .sec_wdata_i (sec_wdata_i),
  .ns_o        (ns_o),
  .sec_o       (sec_o)
);

// File: tb/ns_rtc_test.sv
module ns_rtc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [1:0]  sel = 2'b00;
  logic        ns_we = 1'b0;
  logic [31:0] ns_wd = '0;
  logic        sec_we = 1'b0;
  logic [31:0] sec_wd = '0;
  logic [31:0] ns_q, sec_q;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ns_rtc uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .step_sel_i(sel),
    .ns_we_i(ns_we), .ns_wdata_i(ns_wd), .sec_we_i(sec_we), .sec_wdata_i(sec_wd),
    .ns_o(ns_q), .sec_o(sec_q)
  );

  typedef struct packed {
    logic [1:0]  sel;
    logic        tk;
    logic        nw;
    logic [31:0] nd;
    logic        sw;
    logic [31:0] sd;
    logic [31:0] e_ns;
    logic [31:0] e_sec;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 1'b1, 1'b0, 32'd0,          1'b0, 32'd0,          32'd128,        32'd0,          8'd2},  // R2
    '{2'd0, 1'b1, 1'b0, 32'd0,          1'b0, 32'd0,          32'd256,        32'd0,          8'd2},  // R2
    '{2'd1, 1'b1, 1'b0, 32'd0,          1'b0, 32'd0,          32'd320,        32'd0,          8'd4},  // R4
    '{2'd2, 1'b1, 1'b0, 32'd0,          1'b0, 32'd0,          32'd352,        32'd0,          8'd4},  // R4
    '{2'd3, 1'b1, 1'b0, 32'd0,          1'b0, 32'd0,          32'd384,        32'd0,          8'd4},  // R4
    '{2'd0, 1'b0, 1'b0, 32'd0,          1'b0, 32'd0,          32'd384,        32'd0,          8'd5},  // R5
    '{2'd0, 1'b1, 1'b1, 32'd999999872,  1'b0, 32'd0,          32'd999999872,  32'd0,          8'd8},  // R6 R8
    '{2'd0, 1'b1, 1'b0, 32'd0,          1'b0, 32'd0,          32'd0,          32'd1,          8'd3},  // R3
    '{2'd0, 1'b0, 1'b1, 32'd999999968,  1'b1, 32'd41,         32'd999999968,  32'd41,         8'd7},  // R6 R7
    '{2'd2, 1'b1, 1'b0, 32'd0,          1'b0, 32'd0,          32'd0,          32'd42,         8'd3},  // R3
    '{2'd0, 1'b1, 1'b0, 32'd0,          1'b1, 32'hFFFF_FFFF,  32'd0,          32'hFFFF_FFFF,  8'd8},  // R7 R8
    '{2'd0, 1'b0, 1'b1, 32'd999999936,  1'b0, 32'd0,          32'd999999936,  32'hFFFF_FFFF,  8'd6},  // R6
    '{2'd1, 1'b1, 1'b0, 32'd0,          1'b0, 32'd0,          32'd0,          32'd0,          8'd9},  // R9
    '{2'd0, 1'b0, 1'b1, 32'd1000000005, 1'b0, 32'd0,          32'd1000000005, 32'd0,          8'd10}, // R10
    '{2'd0, 1'b0, 1'b0, 32'd0,          1'b0, 32'd0,          32'd1000000005, 32'd0,          8'd10}, // R10
    '{2'd0, 1'b1, 1'b0, 32'd0,          1'b0, 32'd0,          32'd0,          32'd1,          8'd10}  // R10
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive at negedge, release after the edge, compare at the following negedge.
  task automatic step(input logic [1:0] s, input logic tk, input logic nw, input logic [31:0] nd,
                      input logic sw, input logic [31:0] sd);
    @(negedge clk);
    sel = s; tick = tk; ns_we = nw; ns_wd = nd; sec_we = sw; sec_wd = sd;
    @(posedge clk);
    #1;
    tick = 1'b0; ns_we = 1'b0; sec_we = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ns after reset", ns_q, 32'd0);
    check("R1 sec after reset", sec_q, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].sel, VEC[i].tk, VEC[i].nw, VEC[i].nd, VEC[i].sw, VEC[i].sd);
      check($sformatf("R%0d vec %0d ns", VEC[i].req, i), ns_q, VEC[i].e_ns);
      check($sformatf("R%0d vec %0d sec", VEC[i].req, i), sec_q, VEC[i].e_sec);
    end

    // R1: reset in the middle of a run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 ns after mid-run reset", ns_q, 32'd0);
    check("R1 sec after mid-run reset", sec_q, 32'd0);
    rst_n = 1'b1;

    // R11: twenty 128 ns steps from zero keep the low seven bits clear
    for (int k = 0; k < 20; k++) begin
      step(2'd0, 1'b1, 1'b0, 32'd0, 1'b0, 32'd0);
      check("R11 low bits", {25'd0, ns_q[6:0]}, 32'd0);
    end
    check("R11 ns after 20 steps", ns_q, 32'd2560);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule